// File: doc/BRIEF.md
# Shared-Bus Synchronous Word Store

This block is a small clocked memory of sixteen 8-bit words. Reads and writes pass over one bidirectional data bus. There are no separate input and output data pins. A host selects the block with an active-low select line and picks the direction with a read/not-write line. It places a 4-bit word address on the address pins. On a selected read, the addressed word is captured at the rising clock edge and then driven onto the bus. On a selected write, the block samples the value that the host drives on the bus.

The block drives the bus only through an internal output enable. A parameter chooses how that enable is made. In the registered variant (`OE_COMB = 0`) the enable is a flip-flop. After a read, the first write edge is only a release cycle: the enable falls on that edge and nothing is stored. The word is written on the following edge, after the block has kept off the bus for a whole cycle. In the combinational variant (`OE_COMB = 1`) the enable follows the select and direction lines directly. A write may then follow a read on the very next edge.

Reset is asynchronous on assertion and synchronous on release. It clears the enable and the read register, but it does not clear the stored words.

Top module: `bidir_sram`

## Requirements
- R1: While reset is held, and from the release of reset, the block does not drive the bus. A write on the first cycle after reset completes stores the driven value.
- R2: While `cs_n` is 1, no word is written and the block does not drive the bus, whatever `rd_wr_n` and the bus carry.
- R3: A selected cycle with `rd_wr_n` = 0 and the block off the bus stores the bus value at the address on the rising edge.
- R4: A selected cycle with `rd_wr_n` = 1 captures the addressed word at the rising edge, and the block drives that word on the bus from just after that edge.
- R5: In the registered variant, the block is off the bus in every cycle that follows an edge at which it was not selected for a read.
- R6: In the registered variant, the first write edge after a read stores nothing and releases the bus. The write is stored on the next edge, if the write is still selected then.
- R7: In the combinational variant, the bus is released as soon as `rd_wr_n` goes to 0, and a write directly after a read is stored on its first edge.
- R8: `addr` is a natural binary index with `addr[3]` most significant. All 16 locations hold independent values.
- R9: Stored words keep their values through an assertion of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Active-low reset, asynchronous assertion, synchronized release |
| cs_n | input | 1 | Active-low select |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Word address, bit 3 most significant |
| data | inout | 8 | Shared data bus, driven by the block only when its enable is set |

## Verification
The hardest situation to reach from the pins is the release cycle that follows a read in the registered variant. During that edge the bus still carries the block's own read data. A faulty design would quietly store that value at the write address. The bench first issues a read. It then requests a write to another location but does not drive the bus, and it deselects after that single edge. Reading the target back shows whether the edge wrongly stored data. A full two-edge write sequence then confirms that the delayed write does land. Bus contention is detected because the bench drives patterns whose bitwise OR with the stored data would differ.

// File: rtl/bidir_sram_pkg.sv
package bidir_sram_pkg;
  localparam int unsigned WORD_W_DEF = 8;
  localparam int unsigned IDX_W_DEF  = 4;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/bidir_sram_rst_sync.sv
module bidir_sram_rst_sync
  import bidir_sram_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/bidir_sram_oe_ctrl.sv
module bidir_sram_oe_ctrl
  import bidir_sram_pkg::*;
#(
  parameter bit OE_COMB = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_wr_n,
  output logic oe,
  output logic rd_en,
  output logic wr_en
);
  acc_kind_e kind;

  always_comb begin
    if (cs_n)         kind = ACC_IDLE;
    else if (rd_wr_n) kind = ACC_READ;
    else              kind = ACC_WRITE;
  end

  assign rd_en = rst_n && (kind == ACC_READ);

  generate
    if (OE_COMB) begin : g_comb
      assign oe    = rd_en;
      assign wr_en = rst_n && (kind == ACC_WRITE);

      assert_wr_off_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WRITE) |-> !oe);
    end else begin : g_reg
      logic oe_q;
      logic oe_d;
      logic oe_ce;

      always_comb begin
        oe_ce = (kind == ACC_READ) || oe_q;
        oe_d  = (kind == ACC_READ);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     oe_q <= 1'b0;
        else if (oe_ce) oe_q <= oe_d;
      end

      assign oe    = oe_q;
      assign wr_en = rst_n && (kind == ACC_WRITE) && !oe_q;

      assert_read_sets_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_READ) |=> oe);
      assert_idle_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_READ) |=> !oe);
      assert_release_before_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !oe);
      assert_first_write_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind == ACC_WRITE) && oe) |=> !oe);
    end
  endgenerate

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !oe);
endmodule

// File: rtl/bidir_sram_array.sv
module bidir_sram_array
  import bidir_sram_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned IDX_W  = IDX_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rdata_d;

  generate
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic hit;
      assign hit = wr_en && (idx == IDX_W'(w));
      always_ff @(posedge clk) begin
        if (hit) mem[w] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    rdata_d = mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(idx)] == $past(wdata)));
  assert_one_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
endmodule

// File: rtl/bidir_sram.sv
module bidir_sram
  import bidir_sram_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned IDX_W   = IDX_W_DEF,
  parameter bit          OE_COMB = 1'b0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cs_n,
  input  logic              rd_wr_n,
  input  logic [IDX_W-1:0]  addr,
  inout  wire  [WORD_W-1:0] data
);
  logic              rst_n_i;
  logic              oe;
  logic              rd_en;
  logic              wr_en;
  logic [WORD_W-1:0] rdata;

  bidir_sram_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_i)
  );

  bidir_sram_oe_ctrl #(.OE_COMB(OE_COMB)) u_oe_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .cs_n    (cs_n),
    .rd_wr_n (rd_wr_n),
    .oe      (oe),
    .rd_en   (rd_en),
    .wr_en   (wr_en)
  );

  bidir_sram_array #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n_i),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .idx   (addr),
    .wdata (data),
    .rdata (rdata)
  );

  assign data = oe ? rdata : {WORD_W{1'bz}};

  generate
    if (OE_COMB) begin : g_chk_comb
      assert_deselect_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
        cs_n |-> (!oe && !wr_en));
    end else begin : g_chk_reg
      assert_deselect_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
        cs_n |=> !oe);
      assert_deselect_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
        cs_n |-> !wr_en);
    end
  endgenerate
endmodule

// File: tb/bidir_sram_bench.sv
`timescale 1ns/1ps
module bidir_sram_bench;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       cs_s = 1'b1;
  logic       rw_s = 1'b1;
  logic [3:0] addr_s = '0;
  logic       drv = 1'b0;
  logic [7:0] drv_val = '0;
  logic       mode_c = 1'b0;
  logic       done = 1'b0;
  int         n_chk = 0;
  int         n_err = 0;
  logic [7:0] ref_r [16];
  logic [7:0] ref_c [16];

  wire  [7:0] bus_r;
  wire  [7:0] bus_c;
  logic       cs_n_r;
  logic       cs_n_c;
  logic [7:0] bus_obs;

  always #2.5 clk = ~clk;

  assign cs_n_r  = mode_c | cs_s;
  assign cs_n_c  = ~mode_c | cs_s;
  assign bus_r   = (drv && !mode_c) ? drv_val : 8'bz;
  assign bus_c   = (drv && mode_c) ? drv_val : 8'bz;
  assign bus_obs = mode_c ? bus_c : bus_r;

  bidir_sram #(.OE_COMB(1'b0)) u_bidir_sram (
    .clk(clk), .arst_n(arst_n), .cs_n(cs_n_r), .rd_wr_n(rw_s),
    .addr(addr_s), .data(bus_r));

  bidir_sram #(.OE_COMB(1'b1)) u_bidir_sram_comb (
    .clk(clk), .arst_n(arst_n), .cs_n(cs_n_c), .rd_wr_n(rw_s),
    .addr(addr_s), .data(bus_c));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", tag, mode_c, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    cs_s = 1'b1; rw_s = 1'b1; drv = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_s = 1'b0; rw_s = 1'b0; addr_s = a; drv = 1'b1; drv_val = d;
    @(posedge clk);
    if (mode_c) ref_c[a] = d; else ref_r[a] = d;
    go_idle();
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    cs_s = 1'b0; rw_s = 1'b1; addr_s = a; drv = 1'b0;
    @(posedge clk); #1;
    e = mode_c ? ref_c[a] : ref_r[a];
    check(tag, bus_obs, e);
    go_idle();
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    arst_n = 1'b0;
    repeat (cycles) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R1: write right after reset, and no drive during reset
  task automatic t_reset_state();
    @(negedge clk);
    cs_s = 1'b0; rw_s = 1'b1; addr_s = 4'd2; drv = 1'b1; drv_val = 8'h00;
    @(posedge clk); #1;
    check("R1 bus in reset", bus_obs, 8'h00);
    go_idle();
    arst_n = 1'b1;
    repeat (2) @(negedge clk);
    wr(4'd2, 8'h6D);
    rd(4'd2, "R1 first write after reset");
  endtask

  // R8, R3, R4: fill every location and read back
  task automatic t_fill();
    for (int i = 0; i < 16; i++) wr(4'(i), 8'((i * 37) ^ 8'h5A));
    for (int i = 15; i >= 0; i--) rd(4'(i), "R8 R3 R4 readback");
  endtask

  // R2: deselected cycles neither write nor drive
  task automatic t_deselect();
    wr(4'd5, 8'hC3);
    @(negedge clk);
    cs_s = 1'b1; rw_s = 1'b0; addr_s = 4'd5; drv = 1'b1; drv_val = 8'h99;
    @(posedge clk);
    @(negedge clk);
    rw_s = 1'b1; drv_val = 8'h3C;
    @(posedge clk); #1;
    check("R2 no drive while deselected", bus_obs, 8'h3C);
    go_idle();
    rd(4'd5, "R2 no write while deselected");
  endtask

  // R5: after a read plus one idle edge the bus is free
  task automatic t_release_after_read();
    rd(4'd5, "R4 read before release");
    @(negedge clk);
    drv = 1'b1; drv_val = 8'h3C;
    @(posedge clk); #1;
    check("R5 bus free after idle edge", bus_obs, 8'h3C);
    go_idle();
  endtask

  // R6: registered variant needs a release edge before a write lands
  task automatic t_reg_turnaround();
    wr(4'd7, 8'h11);
    wr(4'd8, 8'h22);
    @(negedge clk);
    cs_s = 1'b0; rw_s = 1'b1; addr_s = 4'd7; drv = 1'b0;
    @(posedge clk); #1;
    check("R4 read drives bus", bus_obs, 8'h11);
    @(negedge clk);
    rw_s = 1'b0; addr_s = 4'd8;
    @(posedge clk);
    go_idle();
    rd(4'd8, "R6 release edge stores nothing");
    @(negedge clk);
    cs_s = 1'b0; rw_s = 1'b1; addr_s = 4'd7; drv = 1'b0;
    @(negedge clk);
    rw_s = 1'b0; addr_s = 4'd8;
    @(negedge clk);
    drv = 1'b1; drv_val = 8'hA5;
    @(posedge clk);
    ref_r[8] = 8'hA5;
    go_idle();
    rd(4'd8, "R6 second edge stores");
  endtask

  // R7: combinational variant writes directly after a read
  task automatic t_comb_back_to_back();
    wr(4'd9, 8'h44);
    wr(4'd10, 8'h0F);
    @(negedge clk);
    cs_s = 1'b0; rw_s = 1'b1; addr_s = 4'd9; drv = 1'b0;
    @(posedge clk); #1;
    check("R4 comb read drives bus", bus_obs, 8'h44);
    @(negedge clk);
    rw_s = 1'b0; addr_s = 4'd10; drv = 1'b1; drv_val = 8'hB0;
    @(posedge clk);
    ref_c[10] = 8'hB0;
    go_idle();
    rd(4'd10, "R7 write on first edge after read");
  endtask

  // R9: contents survive reset
  task automatic t_retain();
    wr(4'd12, 8'h7E);
    do_reset(3);
    rd(4'd12, "R9 retained through reset");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    mode_c = 1'b0;
    t_reset_state();
    t_fill();
    t_deselect();
    t_release_after_read();
    t_reg_turnaround();
    t_retain();
    mode_c = 1'b1;
    @(negedge clk);
    arst_n = 1'b0;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_fill();
    t_deselect();
    t_release_after_read();
    t_comb_back_to_back();
    t_retain();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule